// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM device from power-up to normal operation. After a start pulse it holds the clock enable low for a power-stabilisation wait, raises it for a short settling wait, and then issues the fixed bring-up commands on a plain command/bank/address bus. The order is a precharge of all banks, the extended mode registers 2, 3 and 1, a mode register write that resets the DLL, a second all-bank precharge, two auto-refreshes, and a last mode register write with the DLL reset cleared. A wait counter holds each command apart from the next by the interval that command needs. OCD and extended calibration steps are left out.

The start pulse is taken only while the sequencer is idle. When the last wait has run out, `init_done` rises and stays high until reset. From then on a second counter raises a one-cycle `refresh_req` at a programmable interval. A controller can pass that request on as an auto-refresh. CAS latency, the three command spacings and the refresh interval are static inputs. The two long waits are fixed at build time from a clock-period parameter and nanosecond parameters.

Top module: `ddr2_init_seq`

## Requirements
- R1: While in reset and while idle before an accepted start, `cke` is 0, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `ba` and `addr` are 0, and `init_done` and `refresh_req` are 0.
- R2: In the cycle after `start` is sampled high while idle, `cke` goes low with NOP for PWR_CYC = ceil(PWRUP_NS·1000/CLK_PS) cycles. It is then high with NOP for CKE_CYC = ceil(CKE_NS·1000/CLK_PS) cycles. Each count is at least 1.
- R3: Directly after the high-`cke` wait, the nine commands are issued in this order: precharge-all (0010), mode write (0000) with BA=2, with BA=3, with BA=1, mode write with BA=0 and DLL reset, precharge-all, auto-refresh (0001), auto-refresh, mode write with BA=0 and DLL reset cleared.
- R4: The extended mode writes carry `addr` = 0. Precharge-all carries `addr[10]` = 1, every other address bit 0, and BA = 0. Auto-refresh carries BA = 0 and `addr` = 0.
- R5: The BA=0 mode writes carry burst length 4 in `addr[2:0]` = 3'b010 and `cas_lat` in `addr[6:4]`. The DLL reset bit `addr[8]` is 1 on the first write and 0 on the second. All other address bits are 0.
- R6: The next command follows a precharge-all by exactly `t_rp` cycles, a mode write by exactly `t_mrd` cycles, and an auto-refresh by exactly `t_rfc` cycles. A value of 0 counts as 1. The cycles in between carry NOP with `cke` high.
- R7: `init_done` rises exactly `t_mrd` cycles after the final mode write and stays high until reset. From then on the bus carries NOP with `cke` high.
- R8: Once `init_done` is high, `refresh_req` is a one-cycle pulse in the L-th, 2L-th, … cycle of normal mode, where L = `ref_interval`, and L = 1 when `ref_interval` = 0. It is never high while `init_done` is low.
- R9: A `start` pulse while the sequence is running, or after `init_done`, has no effect on the command stream, the completion cycle or the refresh cadence.
- R10: A command other than NOP is never issued while `cke` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| cas_lat | input | 3 | CAS latency written into the mode register |
| t_mrd | input | T_W | Cycles from a mode write to the next command |
| t_rp | input | T_W | Cycles from precharge-all to the next command |
| t_rfc | input | T_W | Cycles from auto-refresh to the next command |
| ref_interval | input | RI_W | Cycles between refresh requests in normal mode |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | A_W | Address / mode register value |
| init_done | output | 1 | High from normal-mode entry until reset |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
A `start` pulse can arrive in the same cycle as a `refresh_req` pulse. It can also arrive in the same cycle as the sequencer's own timer expiring and moving to the next command. The bench counts ahead from an observed refresh pulse and drives `start` high in exactly the cycle of the next one. It also pulses `start` during the power wait and during the command phase. A behavioural model built from the requirements checks, on every clock, that the command stream, the completion cycle and the refresh cadence are all unchanged by those pulses.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    // Command codes on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_CKE,
        ST_CMD,
        ST_GAP,
        ST_DONE
    } state_e;

    // Which configured spacing follows a command
    typedef enum logic [1:0] {
        GAP_MRD,
        GAP_RP,
        GAP_RFC
    } gap_e;

    typedef struct packed {
        cmd_e       cmd;
        logic [2:0] bank;
        logic       dll_rst;
        logic       a10;
        gap_e       gap;
    } step_t;

    localparam int N_STEPS = 9;

    function automatic step_t mk_step(cmd_e c, logic [2:0] b, logic d, logic a, gap_e g);
        step_t s;
        s.cmd     = c;
        s.bank    = b;
        s.dll_rst = d;
        s.a10     = a;
        s.gap     = g;
        return s;
    endfunction

    // Fixed bring-up order
    function automatic step_t step_of(logic [3:0] idx);
        case (idx)
            4'd0:    return mk_step(CMD_PRE, 3'd0, 1'b0, 1'b1, GAP_RP);
            4'd1:    return mk_step(CMD_MRS, 3'd2, 1'b0, 1'b0, GAP_MRD);
            4'd2:    return mk_step(CMD_MRS, 3'd3, 1'b0, 1'b0, GAP_MRD);
            4'd3:    return mk_step(CMD_MRS, 3'd1, 1'b0, 1'b0, GAP_MRD);
            4'd4:    return mk_step(CMD_MRS, 3'd0, 1'b1, 1'b0, GAP_MRD);
            4'd5:    return mk_step(CMD_PRE, 3'd0, 1'b0, 1'b1, GAP_RP);
            4'd6:    return mk_step(CMD_REF, 3'd0, 1'b0, 1'b0, GAP_RFC);
            4'd7:    return mk_step(CMD_REF, 3'd0, 1'b0, 1'b0, GAP_RFC);
            4'd8:    return mk_step(CMD_MRS, 3'd0, 1'b0, 1'b0, GAP_MRD);
            default: return mk_step(CMD_NOP, 3'd0, 1'b0, 1'b0, GAP_MRD);
        endcase
    endfunction

    // Nanoseconds to whole clock cycles, rounded up, at least 1
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
        longint unsigned r;
        r = (longint'(ns) * 1000 + longint'(clk_ps) - 1) / longint'(clk_ps);
        if (r == 0) r = 1;
        return int'(r);
    endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr2_refresh_timer.sv
module ddr2_refresh_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] interval,
    output logic         pulse
);
    logic [W-1:0] lim;
    logic [W-1:0] cnt;
    logic         wrap;

    assign lim  = (interval == '0) ? W'(1) : interval;
    assign wrap = (cnt >= lim - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end

    assign pulse = en && wrap;

    // R8
    refresh_single_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && lim > W'(1) && $stable(interval)) |=> !pulse);
endmodule

// File: rtl/ddr2_cmd_drive.sv
module ddr2_cmd_drive
    import ddr2_init_pkg::*;
#(
    parameter int BA_W = 3,
    parameter int A_W  = 14
) (
    input  state_e            state,
    input  cmd_e              step_cmd,
    input  logic [2:0]        step_bank,
    input  logic              step_dll,
    input  logic              step_a10,
    input  logic [2:0]        cas_lat,
    output logic              cke,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   ba,
    output logic [A_W-1:0]    addr
);
    always_comb begin
        cke  = (state != ST_IDLE) && (state != ST_PWR);
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (state == ST_CMD) begin
            cmd = step_cmd;
            ba  = BA_W'(step_bank);
            if (step_a10)
                addr[10] = 1'b1;
            if (step_cmd == CMD_MRS && step_bank == 3'd0) begin
                addr[2:0] = 3'b010;
                addr[6:4] = cas_lat;
                addr[8]   = step_dll;
            end
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLK_PS   = 7500,
    parameter int unsigned PWRUP_NS = 200000,
    parameter int unsigned CKE_NS   = 400,
    parameter int          T_W      = 8,
    parameter int          RI_W     = 16,
    parameter int          BA_W     = 3,
    parameter int          A_W      = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cas_lat,
    input  logic [T_W-1:0]    t_mrd,
    input  logic [T_W-1:0]    t_rp,
    input  logic [T_W-1:0]    t_rfc,
    input  logic [RI_W-1:0]   ref_interval,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [A_W-1:0]    addr,
    output logic              init_done,
    output logic              refresh_req
);
    localparam int unsigned PWR_CYC = ns_to_cyc(PWRUP_NS, CLK_PS);
    localparam int unsigned CKE_CYC = ns_to_cyc(CKE_NS, CLK_PS);
    localparam int unsigned BIG_CYC = (PWR_CYC > CKE_CYC) ? PWR_CYC : CKE_CYC;
    localparam int          LONG_W  = $clog2(BIG_CYC + 1);
    localparam int          CNT_W   = (LONG_W > T_W) ? LONG_W : T_W;

    state_e             state, state_nx;
    logic [3:0]         step_q, step_nx;
    step_t              cur;
    logic               last_step;
    logic [T_W-1:0]     gap_raw, gap_eff;
    logic               tmr_load, tmr_zero;
    logic [CNT_W-1:0]   tmr_val;
    cmd_e               cmd_w;

    assign cur       = step_of(step_q);
    assign last_step = (step_q == 4'(N_STEPS - 1));

    always_comb begin
        case (cur.gap)
            GAP_RP:  gap_raw = t_rp;
            GAP_RFC: gap_raw = t_rfc;
            default: gap_raw = t_mrd;
        endcase
        gap_eff = (gap_raw == '0) ? T_W'(1) : gap_raw;
    end

    always_comb begin
        state_nx = state;
        step_nx  = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (start) begin
                state_nx = ST_PWR;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PWR_CYC - 1);
            end
            ST_PWR: if (tmr_zero) begin
                state_nx = ST_CKE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(CKE_CYC - 1);
            end
            ST_CKE: if (tmr_zero) begin
                state_nx = ST_CMD;
                step_nx  = '0;
            end
            ST_CMD: begin
                if (gap_eff == T_W'(1)) begin
                    if (last_step) state_nx = ST_DONE;
                    else           step_nx  = step_q + 4'd1;
                end else begin
                    state_nx = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(gap_eff - T_W'(2));
                end
            end
            ST_GAP: if (tmr_zero) begin
                if (last_step) begin
                    state_nx = ST_DONE;
                end else begin
                    state_nx = ST_CMD;
                    step_nx  = step_q + 4'd1;
                end
            end
            default: state_nx = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step_q <= '0;
        end else begin
            state  <= state_nx;
            step_q <= step_nx;
        end
    end

    ddr2_wait_timer #(.W(CNT_W)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    ddr2_cmd_drive #(.BA_W(BA_W), .A_W(A_W)) u_drive (
        .state     (state),
        .step_cmd  (cur.cmd),
        .step_bank (cur.bank),
        .step_dll  (cur.dll_rst),
        .step_a10  (cur.a10),
        .cas_lat   (cas_lat),
        .cke       (cke),
        .cmd       (cmd_w),
        .ba        (ba),
        .addr      (addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd_w;
    assign init_done = (state == ST_DONE);

    ddr2_refresh_timer #(.W(RI_W)) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .en       (init_done),
        .interval (ref_interval),
        .pulse    (refresh_req)
    );

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R8
    refresh_gated_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> init_done);

    // R10
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |-> cke);

    // R6
    gap_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && gap_eff > T_W'(1)) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R4
    precharge_a10_chk: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[10] && ba == '0));

    // R2
    cke_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWR && !tmr_zero) |=> !cke);
endmodule

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_PS   = 7500;
    localparam int T_PWR_NS   = 1500;
    localparam int T_CKE_NS   = 400;
    localparam int PWR_EXP    = (T_PWR_NS * 1000 + T_CLK_PS - 1) / T_CLK_PS;
    localparam int CKE_EXP    = (T_CKE_NS * 1000 + T_CLK_PS - 1) / T_CLK_PS;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [2:0] cas_lat = 3'd3;
    logic [7:0] t_mrd = 8'd2, t_rp = 8'd3, t_rfc = 8'd19;
    logic [15:0] ref_interval = 16'd37;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
    logic [2:0] ba;
    logic [13:0] addr;

    ddr2_init_seq #(.CLK_PS(T_CLK_PS), .PWRUP_NS(T_PWR_NS), .CKE_NS(T_CKE_NS)) uut (
        .clk(clk), .rst(rst), .start(start), .cas_lat(cas_lat),
        .t_mrd(t_mrd), .t_rp(t_rp), .t_rfc(t_rfc), .ref_interval(ref_interval),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done), .refresh_req(refresh_req));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [21:0] exp_q[$];
    int mode = 0;            // 0 idle, 1 sequence, 2 normal
    logic e_cke, e_done, e_req;
    logic [3:0] e_cmd;
    logic [2:0] e_ba;
    logic [13:0] e_addr;
    int ref_cnt = 0, cyc = 0, start_cyc = 0, done_cyc = -1, gap_total = 0;
    bit r9_phase = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    function automatic int lim_of();
        return (ref_interval == 0) ? 1 : int'(ref_interval);
    endfunction

    function automatic int eff(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic push(input logic k, input logic [3:0] c, input logic [2:0] b, input logic [13:0] a);
        exp_q.push_back({k, c, b, a});
    endtask

    task automatic push_cmd(input logic [3:0] c, input logic [2:0] b, input logic [13:0] a, input int g);
        push(1'b1, c, b, a);
        for (int i = 1; i < g; i++) push(1'b1, C_NOP, 3'd0, 14'd0);
        gap_total += g;
    endtask

    function automatic logic [13:0] mode_word(input logic dll);
        logic [13:0] a = '0;
        a[2:0] = 3'b010;
        a[6:4] = cas_lat;
        a[8]   = dll;
        return a;
    endfunction

    task automatic build_seq();
        gap_total = 0;
        for (int i = 0; i < PWR_EXP; i++) push(1'b0, C_NOP, 3'd0, 14'd0);
        for (int i = 0; i < CKE_EXP; i++) push(1'b1, C_NOP, 3'd0, 14'd0);
        push_cmd(C_PRE, 3'd0, 14'h0400, eff(t_rp));
        push_cmd(C_MRS, 3'd2, 14'd0, eff(t_mrd));
        push_cmd(C_MRS, 3'd3, 14'd0, eff(t_mrd));
        push_cmd(C_MRS, 3'd1, 14'd0, eff(t_mrd));
        push_cmd(C_MRS, 3'd0, mode_word(1'b1), eff(t_mrd));
        push_cmd(C_PRE, 3'd0, 14'h0400, eff(t_rp));
        push_cmd(C_REF, 3'd0, 14'd0, eff(t_rfc));
        push_cmd(C_REF, 3'd0, 14'd0, eff(t_rfc));
        push_cmd(C_MRS, 3'd0, mode_word(1'b0), eff(t_mrd));
    endtask

    task automatic set_idle();
        mode = 0; e_cke = 0; e_cmd = C_NOP; e_ba = 0; e_addr = 0; e_done = 0; e_req = 0;
        exp_q.delete();
    endtask

    initial set_idle();

    // Reference model: compare this cycle, then work out the next one
    always @(negedge clk) begin
        if (rst) begin
            set_idle();
        end else begin
            string tc, ta;
            cyc++;
            tc = (mode == 0) ? "R1" : (mode == 2) ? "R7" : (e_cmd == C_NOP) ? "R6" : "R3";
            ta = (mode == 0) ? "R1" : (e_cmd == C_MRS && e_ba == 0) ? "R5" : (e_cmd == C_NOP) ? "R6" : "R4";
            if (r9_phase) begin tc = "R9"; ta = "R9"; end
            chk((mode == 0) ? "R1" : (r9_phase ? "R9" : "R2"), "cke", cke, e_cke);
            chk(tc, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd);
            chk(ta, "ba", ba, e_ba);
            chk(ta, "addr", addr, e_addr);
            chk((mode == 0) ? "R1" : (r9_phase ? "R9" : "R7"), "init_done", init_done, e_done);
            chk((mode == 0) ? "R1" : (r9_phase ? "R9" : "R8"), "refresh_req", refresh_req, e_req);
            if ({cs_n, ras_n, cas_n, we_n} != C_NOP) chk("R10", "cke with command", cke, 1);
            if (init_done && done_cyc < 0) done_cyc = cyc;

            if (mode == 0 && start) begin
                build_seq();
                start_cyc = cyc;
                mode = 1;
            end else if (mode == 2) begin
                ref_cnt = (ref_cnt >= lim_of() - 1) ? 0 : ref_cnt + 1;
                e_req = (ref_cnt == lim_of() - 1);
            end
            if (mode == 1) begin
                if (exp_q.size() == 0) begin
                    mode = 2; ref_cnt = 0;
                    e_cke = 1; e_cmd = C_NOP; e_ba = 0; e_addr = 0; e_done = 1;
                    e_req = (lim_of() == 1);
                end else begin
                    logic [21:0] e;
                    e = exp_q.pop_front();
                    {e_cke, e_cmd, e_ba, e_addr} = e;
                end
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        done_cyc = -1;
    endtask

    task automatic wait_done_and_check();
        int n = 0;
        while (!init_done && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
        // R9: completion cycle unmoved by busy start pulses
        chk("R9", "done cycle", done_cyc - start_cyc, 1 + PWR_EXP + CKE_EXP + gap_total);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        // Run 1: nominal spacings, busy start in power wait, start on a refresh cycle
        do_reset();
        repeat (6) @(posedge clk);
        pulse_start();
        repeat (40) @(posedge clk);
        r9_phase = 1;
        pulse_start();
        repeat (4) @(posedge clk);
        r9_phase = 0;
        wait_done_and_check();
        @(negedge clk);
        while (!refresh_req) @(negedge clk);
        repeat (37) @(posedge clk);
        #1 start = 1'b1; r9_phase = 1;
        @(posedge clk); #1 start = 1'b0;
        repeat (120) @(posedge clk);
        r9_phase = 0;

        // Run 2: minimum spacings, zero precharge spacing, interval 1, start held two cycles
        do_reset();
        cas_lat = 3'd5; t_mrd = 8'd1; t_rp = 8'd0; t_rfc = 8'd5; ref_interval = 16'd1;
        repeat (3) @(posedge clk);
        @(posedge clk); #1 start = 1'b1;
        repeat (2) @(posedge clk);
        #1 start = 1'b0;
        wait_done_and_check();
        repeat (20) @(posedge clk);

        // Run 3: interval 0 treated as 1, then busy start in the command phase
        do_reset();
        cas_lat = 3'd2; t_mrd = 8'd3; t_rp = 8'd2; t_rfc = 8'd4; ref_interval = 16'd0;
        pulse_start();
        repeat (PWR_EXP + CKE_EXP + 1) @(posedge clk);
        r9_phase = 1;
        pulse_start();
        repeat (3) @(posedge clk);
        r9_phase = 0;
        wait_done_and_check();
        repeat (10) @(posedge clk);

        // Run 4: interval 5 after a fresh reset
        do_reset();
        ref_interval = 16'd5;
        repeat (2) @(posedge clk);
        pulse_start();
        wait_done_and_check();
        repeat (30) @(posedge clk);

        summary();
        $finish;
    end
endmodule